// File: doc/BRIEF.md
# Raster-Op Rectangle Blit Engine

This block copies a rectangle of 8-bit pixels from one place in a frame buffer to another. On the way, each pixel is combined with the pixel already at the destination through one of sixteen two-input boolean functions. Software loads a small register set through a write-only port:

- source and destination start addresses;
- the row pitch of each map;
- the rectangle size;
- a colour;
- a mode word.

It then writes the command register. The engine walks the rectangle row by row through a single synchronous memory port. For each pixel it reads the source, reads the destination, then writes the result. `busy` stays high for the whole operation.

Each axis can be walked backwards so that overlapping copies come out right. The source operand can be replaced by a fixed colour, which turns the engine into a fill or colour-combine unit. The first or the last pixel of the operation can be left unwritten.

Top module: `rop_blit_engine`

## Requirements

- R1: After synchronous reset `busy` is 0 and `mem_we` stays 0 until a start command is accepted.
- R2: The mix code is mode register (index 7) bits [3:0]. Each result bit is the code bit selected by the index {~S,~D}. So code 0 gives 0, 3 gives S, 5 gives D, 6 gives S^D, 1 gives S&D, 7 gives S|D, A gives ~D, C gives ~S, F gives all ones, and every other code follows the same rule.
- R3: The size registers hold the count minus one: width at index 4, height at index 5. Index 0 is the source start, 1 the destination start, 2 the source pitch and 3 the destination pitch. A write to index 8 starts the operation. With both direction bits clear, pixels are processed left to right within a row and rows top to bottom. The address steps +1 per pixel and +pitch per row.
- R4: Mode bit 4 reverses X and mode bit 5 reverses Y. With an axis reversed, the start addresses name the last pixel of that axis, and addresses step by -1 per pixel (X) or by -pitch per row (Y). Overlapping copies in the matching direction read only unmodified source data.
- R5: When mode bit 8 is 1, the colour register (index 6, bits [7:0]) takes the place of the source pixel in every mix.
- R6: Mode bits [7:6] select the draw mode. 0 writes every pixel. 1 suppresses the write of the first pixel of the operation in traversal order. 2 suppresses the write of the last pixel. 3 behaves as 0.
- R7: `busy` rises in the cycle after a start command is accepted and stays high for exactly 3 x width x height cycles. Each pixel costs one source read, one destination read and one write cycle, in that order.
- R8: While `busy` is 1, writes to every register, including further start commands, are ignored. The running and all later operations use the values loaded before the start.
- R9: Only bits [11:0] of the size and pitch registers are kept. The upper written bits are dropped.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 22 | Register write data |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 22 | Frame-buffer address |
| mem_we | output | 1 | Frame-buffer write enable |
| mem_wdata | output | 8 | Pixel written to the frame buffer |
| mem_rdata | input | 8 | Pixel read, valid one cycle after its address |

## Verification

Two functions can meet in one cycle: a register write or a second start command, and the engine's own pixel pass, including its write phase. The bench provokes this by writing a new width, a new mode and a start command while a blit is running. The scoreboard then judges whether the write stream of the running blit stays unchanged. A follow-up blit, started without reloading any register, must still use the old width and mix code.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RD_SRC,
    PH_RD_DST,
    PH_WRITE
  } phase_e;

  // register indices
  localparam logic [3:0] RI_SRC    = 4'd0;
  localparam logic [3:0] RI_DST    = 4'd1;
  localparam logic [3:0] RI_SPITCH = 4'd2;
  localparam logic [3:0] RI_DPITCH = 4'd3;
  localparam logic [3:0] RI_WIDTH  = 4'd4;
  localparam logic [3:0] RI_HEIGHT = 4'd5;
  localparam logic [3:0] RI_COLOUR = 4'd6;
  localparam logic [3:0] RI_MODE   = 4'd7;
  localparam logic [3:0] RI_GO     = 4'd8;

  // draw modes
  localparam logic [1:0] DM_SKIP_FIRST = 2'd1;
  localparam logic [1:0] DM_SKIP_LAST  = 2'd2;

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          busy,
  output logic [AW-1:0] src_base,
  output logic [AW-1:0] dst_base,
  output logic [DW-1:0] src_pitch,
  output logic [DW-1:0] dst_pitch,
  output logic [DW-1:0] w_m1,
  output logic [DW-1:0] h_m1,
  output logic [PW-1:0] colour,
  output logic [3:0]    mix_code,
  output logic          xrev,
  output logic          yrev,
  output logic [1:0]    draw_mode,
  output logic          use_colour,
  output logic          start
);

  logic wr_ok;
  assign wr_ok = cfg_we && !busy;
  assign start = wr_ok && (cfg_addr == RI_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base   <= '0;
      dst_base   <= '0;
      src_pitch  <= '0;
      dst_pitch  <= '0;
      w_m1       <= '0;
      h_m1       <= '0;
      colour     <= '0;
      mix_code   <= 4'h3;
      xrev       <= 1'b0;
      yrev       <= 1'b0;
      draw_mode  <= '0;
      use_colour <= 1'b0;
    end else if (wr_ok) begin
      case (cfg_addr)
        RI_SRC:    src_base  <= cfg_wdata;
        RI_DST:    dst_base  <= cfg_wdata;
        RI_SPITCH: src_pitch <= cfg_wdata[DW-1:0];
        RI_DPITCH: dst_pitch <= cfg_wdata[DW-1:0];
        RI_WIDTH:  w_m1      <= cfg_wdata[DW-1:0];
        RI_HEIGHT: h_m1      <= cfg_wdata[DW-1:0];
        RI_COLOUR: colour    <= cfg_wdata[PW-1:0];
        RI_MODE: begin
          mix_code   <= cfg_wdata[3:0];
          xrev       <= cfg_wdata[4];
          yrev       <= cfg_wdata[5];
          draw_mode  <= cfg_wdata[7:6];
          use_colour <= cfg_wdata[8];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blit_mix.sv
module blit_mix #(
  parameter int PW = 8
) (
  input  logic [3:0]    code,
  input  logic [PW-1:0] s,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] r
);

  // each output bit looks up the code with index {~s,~d}
  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign r[i] = code[{~s[i], ~d[i]}];
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [DW-1:0] src_pitch,
  input  logic [DW-1:0] dst_pitch,
  input  logic [DW-1:0] w_m1,
  input  logic [DW-1:0] h_m1,
  input  logic          xrev,
  input  logic          yrev,
  input  logic [1:0]    draw_mode,
  input  logic [PW-1:0] mem_rdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [PW-1:0] src_pix
);

  localparam int PADW = AW - DW;

  phase_e        phase;
  logic [DW-1:0] x_cnt, y_cnt;
  logic [AW-1:0] src_row, dst_row, src_cur, dst_cur;
  logic [AW-1:0] src_row_n, dst_row_n, src_cur_n, dst_cur_n;
  logic [AW-1:0] sp_ext, dp_ext;
  logic          row_end, last_pix, first_pix, skip;

  assign sp_ext    = {{PADW{1'b0}}, src_pitch};
  assign dp_ext    = {{PADW{1'b0}}, dst_pitch};
  assign src_row_n = yrev ? src_row - sp_ext : src_row + sp_ext;
  assign dst_row_n = yrev ? dst_row - dp_ext : dst_row + dp_ext;
  assign src_cur_n = xrev ? src_cur - 1'b1 : src_cur + 1'b1;
  assign dst_cur_n = xrev ? dst_cur - 1'b1 : dst_cur + 1'b1;

  assign row_end   = (x_cnt == w_m1);
  assign last_pix  = row_end && (y_cnt == h_m1);
  assign first_pix = (x_cnt == '0) && (y_cnt == '0);
  assign skip      = ((draw_mode == DM_SKIP_FIRST) && first_pix) ||
                     ((draw_mode == DM_SKIP_LAST)  && last_pix);

  assign busy     = (phase != PH_IDLE);
  assign mem_addr = (phase == PH_RD_SRC) ? src_cur : dst_cur;
  assign mem_we   = (phase == PH_WRITE) && !skip;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      x_cnt   <= '0;
      y_cnt   <= '0;
      src_row <= '0;
      dst_row <= '0;
      src_cur <= '0;
      dst_cur <= '0;
      src_pix <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_RD_SRC;
          x_cnt   <= '0;
          y_cnt   <= '0;
          src_row <= src_base;
          src_cur <= src_base;
          dst_row <= dst_base;
          dst_cur <= dst_base;
        end
        PH_RD_SRC: phase <= PH_RD_DST;
        PH_RD_DST: begin
          src_pix <= mem_rdata;
          phase   <= PH_WRITE;
        end
        PH_WRITE: begin
          if (last_pix) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_RD_SRC;
            if (row_end) begin
              x_cnt   <= '0;
              y_cnt   <= y_cnt + 1'b1;
              src_row <= src_row_n;
              src_cur <= src_row_n;
              dst_row <= dst_row_n;
              dst_cur <= dst_row_n;
            end else begin
              x_cnt   <= x_cnt + 1'b1;
              src_cur <= src_cur_n;
              dst_cur <= dst_cur_n;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rop_blit_engine.sv
module rop_blit_engine #(
  parameter int AW = 22,
  parameter int DW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata
);

  logic [AW-1:0] src_base, dst_base;
  logic [DW-1:0] src_pitch, dst_pitch, w_m1, h_m1;
  logic [PW-1:0] colour, src_pix, s_opnd;
  logic [3:0]    mix_code;
  logic [1:0]    draw_mode;
  logic          xrev, yrev, use_colour, start;

  blit_regs #(.AW(AW), .DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .w_m1(w_m1), .h_m1(h_m1), .colour(colour), .mix_code(mix_code),
    .xrev(xrev), .yrev(yrev), .draw_mode(draw_mode),
    .use_colour(use_colour), .start(start)
  );

  blit_walker #(.AW(AW), .DW(DW), .PW(PW)) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .w_m1(w_m1), .h_m1(h_m1), .xrev(xrev), .yrev(yrev),
    .draw_mode(draw_mode), .mem_rdata(mem_rdata),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .src_pix(src_pix)
  );

  assign s_opnd = use_colour ? colour : src_pix;

  blit_mix #(.PW(PW)) u_mix (
    .code(mix_code), .s(s_opnd), .d(mem_rdata), .r(mem_wdata)
  );

endmodule

// File: rtl/blit_chk.sv
module blit_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [3:0]    cfg_addr,
  input logic          busy,
  input logic          mem_we,
  input logic [PW-1:0] mem_wdata,
  input logic [PW-1:0] mem_rdata,
  input logic [3:0]    mix_code
);

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we); // R1

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 4'd8 && !busy) |=> busy); // R7

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R7

  AST_INVERT_DEST: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mix_code == 4'hA) |-> (mem_wdata == ~mem_rdata)); // R2

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mix_code)); // R8

endmodule

bind rop_blit_engine blit_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .busy(busy),
  .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .mix_code(mix_code)
);

// File: tb/rop_blit_engine_bench.sv
module rop_blit_engine_bench;

  localparam int AW = 22;
  localparam int PW = 8;

  typedef struct {
    logic [AW-1:0] a;
    logic [PW-1:0] d;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic [PW-1:0] mem_rdata = '0;

  logic [PW-1:0] mem [0:4095];
  logic [PW-1:0] refm [0:4095];
  exp_t          q [$];
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  // bench copy of the loaded configuration
  int b_src, b_dst, b_sp, b_dp, b_w, b_h, b_col, b_mix, b_dm;
  bit b_xr, b_yr, b_uc;

  rop_blit_engine u_rop_blit_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mixf(int code, logic [PW-1:0] s, logic [PW-1:0] d);
    case (code)
      0:  return '0;
      1:  return s & d;
      2:  return s & ~d;
      3:  return s;
      4:  return ~s & d;
      5:  return d;
      6:  return s ^ d;
      7:  return s | d;
      8:  return ~s & ~d;
      9:  return s ^ ~d;
      10: return ~d;
      11: return s | ~d;
      12: return ~s;
      13: return ~s | d;
      14: return ~s | ~d;
      default: return '1;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (q.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'(mem_addr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(mem_addr == e.a, {e.tag, " addr"}, int'(mem_addr), int'(e.a));
        check(mem_wdata == e.d, {e.tag, " data"}, int'(mem_wdata), int'(e.d));
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(int src, int dst, int sp, int dp, int w, int h,
                       int mix, bit xr, bit yr, int dm, bit uc, int col);
    b_src = src; b_dst = dst; b_sp = sp; b_dp = dp; b_w = w; b_h = h;
    b_mix = mix; b_xr = xr; b_yr = yr; b_dm = dm; b_uc = uc; b_col = col;
    wr(4'd0, AW'(src));
    wr(4'd1, AW'(dst));
    wr(4'd2, AW'(sp));
    wr(4'd3, AW'(dp));
    wr(4'd4, AW'(w - 1));
    wr(4'd5, AW'(h - 1));
    wr(4'd6, AW'(col));
    wr(4'd7, AW'({uc, dm[1:0], yr, xr, mix[3:0]}));
  endtask

  task automatic predict(string tag);
    int n;
    n = b_w * b_h;
    for (int y = 0; y < b_h; y++) begin
      for (int x = 0; x < b_w; x++) begin
        int sa, da, idx;
        logic [PW-1:0] s, d, r;
        sa = b_src + (b_xr ? -x : x) + (b_yr ? -y : y) * b_sp;
        da = b_dst + (b_xr ? -x : x) + (b_yr ? -y : y) * b_dp;
        idx = y * b_w + x;
        s = b_uc ? PW'(b_col) : refm[sa & 4095];
        d = refm[da & 4095];
        r = mixf(b_mix, s, d);
        if (!((b_dm == 1 && idx == 0) || (b_dm == 2 && idx == n - 1))) begin
          exp_t e;
          refm[da & 4095] = r;
          e.a = AW'(da); e.d = r; e.tag = tag;
          q.push_back(e);
        end
      end
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run(string tag);
    int cyc;
    predict(tag);
    wr(4'd8, '0);
    wait_idle(cyc);
    check(cyc == 3 * b_w * b_h, "R7 busy cycles", cyc, 3 * b_w * b_h);
    check(q.size() == 0, {tag, " all writes seen"}, q.size(), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int cyc;
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = PW'(i * 37 + 11);
      refm[i] = PW'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);

    // R3 forward copy
    setup(100, 600, 16, 20, 4, 3, 3, 0, 0, 0, 0, 0);
    run("R3 forward copy");

    // R2 every mix code
    for (int c = 0; c < 16; c++) begin
      setup(300 + c * 4, 900 + c * 4, 32, 32, 2, 2, c, 0, 0, 0, 0, 0);
      run("R2 mix code");
    end

    // R4 overlapping copy, both axes reversed
    setup(1200 + 3 + 2 * 16, 1200 + 3 + 2 * 16 + 17, 16, 16, 4, 3, 3, 1, 1, 0, 0, 0);
    run("R4 reverse xy overlap");
    // R4 X reversed only
    setup(1500 + 4, 1500 + 5, 16, 16, 5, 2, 3, 1, 0, 0, 0, 0);
    run("R4 reverse x");

    // R5 colour replaces source
    setup(100, 1800, 16, 16, 3, 2, 6, 0, 0, 0, 1, 8'h5A);
    run("R5 colour xor");
    setup(100, 1900, 16, 16, 3, 1, 3, 0, 0, 0, 1, 8'hC3);
    run("R5 colour fill");

    // R6 draw modes
    setup(2000, 2200, 16, 16, 3, 2, 12, 0, 0, 1, 0, 0);
    run("R6 skip first");
    setup(2000, 2300, 16, 16, 3, 2, 12, 0, 0, 2, 0, 0);
    run("R6 skip last");
    setup(2000, 2400, 16, 16, 3, 2, 12, 0, 0, 3, 0, 0);
    run("R6 mode three draws all");

    // R3 single pixel
    setup(2500, 2600, 16, 16, 1, 1, 7, 0, 0, 0, 0, 0);
    run("R3 single pixel");

    // R9 upper size bits dropped
    setup(2700, 2800, 16, 16, 1, 2, 3, 0, 0, 0, 0, 0);
    wr(4'd4, 22'h3F002);
    b_w = 3;
    run("R9 width upper bits");

    // R8 writes during busy are ignored
    setup(3000, 3100, 16, 16, 4, 3, 6, 0, 0, 0, 0, 0);
    predict("R8 running op");
    wr(4'd8, '0);
    wr(4'd4, 22'd0);
    wr(4'd7, 22'd0);
    wr(4'd8, '0);
    wait_idle(cyc);
    check(q.size() == 0, "R8 running op unchanged", q.size(), 0);
    @(negedge clk);
    check(busy == 1'b0, "R8 start while busy ignored", busy, 0);
    run("R8 old config kept");

    finish_up();
  end

endmodule